// File: doc/BRIEF.md
# Interrupt Source Masking and Routing Register Bank

This block holds the control state for each source of a 32-input interrupt controller and forms the masked status words from that state. Every hardware request line is level-sensitive and is retimed into the local clock. A software register can raise any source in addition to its line. The enable register gates the normal request path. A per-source routing register steers each pending source either to the normal path or to the fast path. The fast path ignores the enable register.

The block drives three status words. The raw word holds every pending source. The normal word holds the enabled sources that are routed to the normal path. The fast word holds the sources that are routed to the fast path. A single fast request output is high while any fast source is pending. Downstream vectoring and priority logic take the normal status word directly from the port.

A plain word-addressed port gives access to the registers. Enable and software-trigger each have a separate write-one-to-set address and write-one-to-clear address, so software never needs a read-modify-write sequence. A read returns its data one cycle after the strobe. A read of an address outside the map returns zero and pulses an error strobe.

Top module: `irq_route_regs`

## Requirements
- R1: The raw word equals the synchronized hardware lines ORed with the software-trigger register. A line change applied before clock edge k appears in the raw word after edge k+1 (two-flop retiming), and not after edge k alone.
- R2: The normal status equals raw AND enable AND NOT route. The fast status equals raw AND route, with no dependence on enable.
- R3: `fast_req` is 1 exactly when the fast status is nonzero.
- R4: A read strobe at word address A places the data on `rd_data` in the following cycle. The readable words are: 0 normal status, 1 fast status, 2 raw, 3 route register (read/write, 1 = fast path), 4 enable register, 6 software-trigger register and 8 lock bit (bit 0, zero above it).
- R5: Writing word 4 ORs the data into the enable register. Writing word 5 clears every enable bit written as 1. Neither write changes any other bit.
- R6: Writing word 6 ORs the data into the software-trigger register. Writing word 7 clears every software-trigger bit written as 1.
- R7: Writes to words 0, 1 and 2 change no state. A write to word 8 stores only data bit 0.
- R8: Reads of word addresses 0x3F8 through 0x3FF return, in order, the bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1 in bits 7:0, with zeros above.
- R9: A read of any other address (including words 5 and 7) returns zero and raises `bus_err` for exactly the cycle in which that read data is presented. Writes to unmapped addresses change no state and raise no error.
- R10: Reset clears the enable, route, software-trigger and lock registers and both synchronizer stages, so all status outputs and `fast_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | NSRC | Level-sensitive hardware request lines |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| rd_data | output | DW | Read data, valid the cycle after a read strobe |
| bus_err | output | 1 | Unmapped-read strobe, aligned with rd_data |
| stat_raw | output | NSRC | Pending sources |
| stat_norm | output | NSRC | Enabled sources routed to the normal path |
| stat_fast | output | NSRC | Sources routed to the fast path |
| fast_req | output | 1 | Fast-path request |

## Verification
The hardest case to reach is the interaction of all four inputs to a single source bit, namely the line, the software trigger, enable and route. This case matters most when the line and the software trigger both raise the same source and only one of them is later removed. The bench sweeps the combinations arithmetically over all 32 bits at once. For each combination it programs the registers through the set and clear addresses, drives the lines and waits out the two retiming stages before it compares all three status words with values it computes itself. A walking single-bit pass then confirms the routing of every bit on its own.

// File: rtl/irq_rr_pkg.sv
package irq_rr_pkg;

    localparam int unsigned NSRC_DEF = 32;
    localparam int unsigned DW_DEF   = 32;
    localparam int unsigned AW_DEF   = 10;

    // Word offsets inside the low page; order matches the software map.
    typedef enum logic [3:0] {
        W_NORM_STAT = 4'd0,
        W_FAST_STAT = 4'd1,
        W_RAW_STAT  = 4'd2,
        W_ROUTE     = 4'd3,
        W_EN_SET    = 4'd4,
        W_EN_CLR    = 4'd5,
        W_SW_SET    = 4'd6,
        W_SW_CLR    = 4'd7,
        W_LOCK      = 4'd8
    } word_e;

    // Identification block occupies the last eight words of a 1024-word page.
    localparam logic [9:0] ID_WORD_BASE = 10'h3F8;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h90;
            3'd1: b = 8'h11;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            3'd7: b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q[i] <= 1'b0;
                stage2_q[i] <= 1'b0;
            end else begin
                stage1_q[i] <= d[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] val_q;
    logic [W-1:0] val_d;

    always_comb begin
        val_d = val_q;
        if (load_en) begin
            val_d = wdata;
        end else if (set_en) begin
            val_d = val_q | wdata;
        end else if (clr_en) begin
            val_d = val_q & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_rr_pkg::*;
#(
    parameter int unsigned NSRC = NSRC_DEF,
    parameter int unsigned DW   = DW_DEF,
    parameter int unsigned AW   = AW_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] hw_req,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   rd_data,
    output logic            bus_err,
    output logic [NSRC-1:0] stat_raw,
    output logic [NSRC-1:0] stat_norm,
    output logic [NSRC-1:0] stat_fast,
    output logic            fast_req
);

    localparam int unsigned LOW_BITS = 4;
    localparam int unsigned ID_BITS  = 3;

    // ---------------- address decode ----------------
    logic        wr_stb;
    logic        rd_stb;
    logic        low_page;
    logic        id_page;
    word_e       word_sel;

    assign wr_stb   = bus_sel &  bus_wr;
    assign rd_stb   = bus_sel & ~bus_wr;
    assign low_page = (bus_addr[AW-1:LOW_BITS] == '0);
    assign id_page  = (bus_addr[AW-1:ID_BITS] == ID_WORD_BASE[AW-1:ID_BITS]);
    assign word_sel = word_e'(bus_addr[LOW_BITS-1:0]);

    logic wr_route, wr_en_set, wr_en_clr, wr_sw_set, wr_sw_clr, wr_lock;

    assign wr_route  = wr_stb & low_page & (word_sel == W_ROUTE);
    assign wr_en_set = wr_stb & low_page & (word_sel == W_EN_SET);
    assign wr_en_clr = wr_stb & low_page & (word_sel == W_EN_CLR);
    assign wr_sw_set = wr_stb & low_page & (word_sel == W_SW_SET);
    assign wr_sw_clr = wr_stb & low_page & (word_sel == W_SW_CLR);
    assign wr_lock   = wr_stb & low_page & (word_sel == W_LOCK);

    // ---------------- control state ----------------
    logic [NSRC-1:0] hw_sync;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] route_q;
    logic [NSRC-1:0] soft_q;
    logic            prot_q;

    irq_sync2 #(.W(NSRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hw_req),
        .q     (hw_sync)
    );

    irq_setclr_reg #(.W(NSRC)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (1'b0),
        .set_en  (wr_en_set),
        .clr_en  (wr_en_clr),
        .wdata   (bus_wdata[NSRC-1:0]),
        .q       (en_q)
    );

    irq_setclr_reg #(.W(NSRC)) u_soft (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (1'b0),
        .set_en  (wr_sw_set),
        .clr_en  (wr_sw_clr),
        .wdata   (bus_wdata[NSRC-1:0]),
        .q       (soft_q)
    );

    irq_setclr_reg #(.W(NSRC)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (wr_route),
        .set_en  (1'b0),
        .clr_en  (1'b0),
        .wdata   (bus_wdata[NSRC-1:0]),
        .q       (route_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
        end else if (wr_lock) begin
            prot_q <= bus_wdata[0];
        end
    end

    // ---------------- status words ----------------
    logic [NSRC-1:0] raw_w;

    assign raw_w     = hw_sync | soft_q;
    assign stat_raw  = raw_w;
    assign stat_norm = raw_w & en_q & ~route_q;
    assign stat_fast = raw_w & route_q;
    assign fast_req  = |(raw_w & route_q);

    // ---------------- read path ----------------
    logic [DW-1:0] rd_word;
    logic          rd_hit;

    always_comb begin
        rd_word = '0;
        rd_hit  = 1'b0;
        if (id_page) begin
            rd_hit      = 1'b1;
            rd_word[7:0] = ident_byte(bus_addr[ID_BITS-1:0]);
        end else if (low_page) begin
            rd_hit = 1'b1;
            case (word_sel)
                W_NORM_STAT: rd_word[NSRC-1:0] = stat_norm;
                W_FAST_STAT: rd_word[NSRC-1:0] = stat_fast;
                W_RAW_STAT:  rd_word[NSRC-1:0] = raw_w;
                W_ROUTE:     rd_word[NSRC-1:0] = route_q;
                W_EN_SET:    rd_word[NSRC-1:0] = en_q;
                W_SW_SET:    rd_word[NSRC-1:0] = soft_q;
                W_LOCK:      rd_word[0]        = prot_q;
                default:     rd_hit            = 1'b0;
            endcase
        end
    end

    logic [DW-1:0] rd_data_q;
    logic          err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            err_q     <= 1'b0;
        end else begin
            err_q <= rd_stb & ~rd_hit;
            if (rd_stb) begin
                rd_data_q <= rd_hit ? rd_word : '0;
            end
        end
    end

    assign rd_data = rd_data_q;
    assign bus_err = err_q;

endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
    parameter int unsigned NSRC = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned AW   = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic            bus_err,
    input logic [NSRC-1:0] stat_raw,
    input logic [NSRC-1:0] stat_norm,
    input logic [NSRC-1:0] stat_fast,
    input logic            fast_req,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] soft_q,
    input logic [NSRC-1:0] route_q
);

    logic wr_is_en_set, wr_is_en_clr, wr_is_sw_set, wr_is_status;
    assign wr_is_en_set = bus_sel && bus_wr && (bus_addr == AW'(4));
    assign wr_is_en_clr = bus_sel && bus_wr && (bus_addr == AW'(5));
    assign wr_is_sw_set = bus_sel && bus_wr && (bus_addr == AW'(6));
    assign wr_is_status = bus_sel && bus_wr && (bus_addr < AW'(3));

    p_fast_within_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_fast & ~stat_raw) == '0);

    p_paths_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_norm & stat_fast) == '0);

    p_fast_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req |-> (stat_raw != '0));

    p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_is_en_set |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    p_en_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_is_en_clr |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

    p_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_is_sw_set |=> ((soft_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

    p_status_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_is_status |=> ($stable(en_q) && $stable(soft_q) && $stable(route_q)));

    p_err_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel && !bus_wr));

endmodule

bind irq_route_regs irq_route_regs_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_err   (bus_err),
    .stat_raw  (stat_raw),
    .stat_norm (stat_norm),
    .stat_fast (stat_fast),
    .fast_req  (fast_req),
    .en_q      (en_q),
    .soft_q    (soft_q),
    .route_q   (route_q)
);

// File: tb/tb_irq_route_regs.sv
module tb_irq_route_regs;

    localparam int unsigned NSRC = 32;
    localparam int unsigned DW   = 32;
    localparam int unsigned AW   = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] hw_req = '0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   rd_data;
    logic            bus_err;
    logic [NSRC-1:0] stat_raw, stat_norm, stat_fast;
    logic            fast_req;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // bench model
    logic [31:0] m_en = '0, m_route = '0, m_soft = '0, m_hw = '0;

    always #10 clk = ~clk;

    irq_route_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .bus_err(bus_err),
        .stat_raw(stat_raw), .stat_norm(stat_norm), .stat_fast(stat_fast), .fast_req(fast_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
        @(negedge clk);
        bus_sel = 1'b0;
        d = rd_data; e = bus_err;
    endtask

    task automatic check_status(input string req);
        logic [31:0] raw;
        raw = m_hw | m_soft;
        chk({req, " raw"},  stat_raw, raw);
        chk({req, " norm"}, stat_norm, raw & m_en & ~m_route);
        chk({req, " fast"}, stat_fast, raw & m_route);
        chk({req, " fast_req R3"}, {31'd0, fast_req}, {31'd0, (raw & m_route) != 0});
    endtask

    task automatic apply(input logic [31:0] hw, input logic [31:0] sw,
                         input logic [31:0] en, input logic [31:0] rt);
        wr(5, 32'hFFFF_FFFF); wr(4, en);
        wr(7, 32'hFFFF_FFFF); wr(6, sw);
        wr(3, rt);
        m_en = en; m_soft = sw; m_route = rt; m_hw = hw;
        @(negedge clk); hw_req = hw;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        logic e;
        logic [7:0] idv [8];
        idv[0] = 8'h90; idv[1] = 8'h11; idv[2] = 8'h04; idv[3] = 8'h00;
        idv[4] = 8'h0D; idv[5] = 8'hF0; idv[6] = 8'h05; idv[7] = 8'hB1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        check_status("R10");
        rd(3, d, e); chk("R10 route", d, 0);
        rd(4, d, e); chk("R10 enable", d, 0);
        rd(6, d, e); chk("R10 soft", d, 0);
        rd(8, d, e); chk("R10 lock", d, 0);

        // R1 two-stage latency
        @(negedge clk); hw_req = 32'h0000_0100;
        @(negedge clk); chk("R1 after one edge", stat_raw, 0);
        @(negedge clk); chk("R1 after two edges", stat_raw, 32'h0000_0100);
        @(negedge clk); hw_req = '0;
        @(negedge clk); @(negedge clk);

        // R5 / R6 set and clear
        wr(4, 32'h0000_00F0); wr(4, 32'h0000_0F00); rd(4, d, e); chk("R5 set", d, 32'h0000_0FF0);
        wr(5, 32'h0000_0330); rd(4, d, e); chk("R5 clr", d, 32'h0000_0CC0);
        wr(6, 32'hA000_0000); wr(6, 32'h0000_0005); rd(6, d, e); chk("R6 set", d, 32'hA000_0005);
        wr(7, 32'h8000_0001); rd(6, d, e); chk("R6 clr", d, 32'h2000_0004);
        m_en = 32'h0000_0CC0; m_soft = 32'h2000_0004;
        wr(3, 32'h2000_0000); m_route = 32'h2000_0000;
        rd(3, d, e); chk("R4 route readback", d, 32'h2000_0000);
        check_status("R2");
        rd(0, d, e); chk("R4 norm word", d, (m_soft) & m_en & ~m_route);
        rd(1, d, e); chk("R4 fast word", d, m_soft & m_route);
        rd(2, d, e); chk("R4 raw word", d, m_soft);

        // R7 ignored writes, lock bit 0 only
        wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
        rd(4, d, e); chk("R7 enable untouched", d, m_en);
        rd(6, d, e); chk("R7 soft untouched", d, m_soft);
        rd(3, d, e); chk("R7 route untouched", d, m_route);
        check_status("R7");
        wr(8, 32'hFFFF_FFFE); rd(8, d, e); chk("R7 lock bit0 only", d, 0);
        wr(8, 32'h0000_0003); rd(8, d, e); chk("R7 lock set", d, 1);

        // R8 identification
        for (int i = 0; i < 8; i++) begin
            rd(10'h3F8 + i, d, e);
            chk("R8 id", d, {24'd0, idv[i]});
            chk("R8 id no err", {31'd0, e}, 0);
        end

        // R9 unmapped reads and writes
        begin
            int bad [6];
            bad[0] = 5; bad[1] = 7; bad[2] = 9; bad[3] = 15; bad[4] = 10'h3F7; bad[5] = 10'h100;
            for (int i = 0; i < 6; i++) begin
                rd(bad[i], d, e);
                chk("R9 data", d, 0);
                chk("R9 err", {31'd0, e}, 1);
                @(negedge clk); chk("R9 err one cycle", {31'd0, bus_err}, 0);
            end
        end
        wr(9, 32'hFFFF_FFFF); chk("R9 write no err", {31'd0, bus_err}, 0);
        wr(10'h104, 32'hFFFF_FFFF);
        rd(4, d, e); chk("R9 enable untouched", d, m_en);
        rd(3, d, e); chk("R9 route untouched", d, m_route);

        // R2/R1 arithmetic sweep over combinations
        for (int k = 0; k < 48; k++) begin
            apply(32'(k * 32'h9E37_79B9), 32'(k * 32'h85EB_CA6B) & 32'h0F0F_F0F0,
                  32'(k * 32'hC2B2_AE35), 32'(k * 32'h27D4_EB2F));
            check_status("R2 sweep");
        end

        // walking bit: hw only, soft only, routed or not
        for (int b = 0; b < 32; b++) begin
            apply(32'd1 << b, 32'd0, 32'hFFFF_FFFF, 32'd0);
            check_status("R2 walk norm");
            apply(32'd0, 32'd1 << b, 32'd0, 32'd1 << b);
            check_status("R3 walk fast");
        end

        // line and software on same bit; removing one keeps it pending
        apply(32'h0000_0010, 32'h0000_0010, 32'h0000_0010, 32'd0);
        @(negedge clk); hw_req = '0; m_hw = '0;
        @(negedge clk); @(negedge clk);
        check_status("R1 soft holds");

        // R10 mid-run reset
        apply(32'h0, 32'h00FF_0000, 32'hFFFF_0000, 32'h0F00_0000);
        wr(8, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_en = 0; m_soft = 0; m_route = 0;
        check_status("R10 reset again");
        rd(8, d, e); chk("R10 lock cleared", d, 0);
        rd(4, d, e); chk("R10 enable cleared", d, 0);

        finish_run();
    end

endmodule